// File: doc/BRIEF.md
# Key-Protected Direction-Mode Write Gate

This block holds a single memory-mapped lock word that decides whether the direction-mode registers of a group of GPIO banks may be written. Software engages the gate by storing a fixed 16-bit key in the low half of the lock word. It disengages the gate by storing an all-zero word. Any other value leaves the gate where it was.

The gate state is held in one flop. It fans out as one write-permit line per attached bank, so every bank sees the same permit on the same cycle. The lock word reports the gate state in its top bit and returns zero in every other bit. The key itself is never stored, so it cannot be read back.

Top module: `modelock_gate`

## Requirements
- R1: After reset, the gate is closed. Every bank permit line is 0, and a read of the lock word returns 32'h0000_0000.
- R2: A write to the lock word whose bits 15:0 equal 16'hD42F opens the gate. All permit lines are 1 from the clock edge after the write onward.
- R3: A write of the full word 32'h0000_0000 to the lock word closes the gate. All permit lines are 0 from the clock edge after the write onward.
- R4: A write to the lock word of a nonzero value whose bits 15:0 are not 16'hD42F leaves the gate state unchanged, whether the gate was open or closed.
- R5: A read of the lock word returns the gate state in bit 31 (1 = open). Bits 30:0 read as 0 whatever was last written, so the key is not readable.
- R6: Every one of the NUM_BANKS permit lines carries the same value on every cycle.
- R7: Writes to any word address other than LOCK_ADDR (default 2) do not change the gate. Reads of those addresses return 0.
- R8: Bits 31:16 of the write data play no part in key matching. For example, 32'hFFFF_D42F opens the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | ADDR_W | Word address of the access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| bank_mode_we | output | NUM_BANKS | Per-bank permit to write the direction-mode registers |

## Verification
The hardest condition to reach is a write that lands while the gate is already open but carries a value that should be ignored. Examples are a near-miss of the key or a nonzero word with a zero key field. Such a write must not silently close the gate, and it is easy to miss because most sequences return to the closed state first.

The stimulus therefore sweeps the sixteen single-bit corruptions of the key, plus a set of other patterns. It does so twice: once from the closed state and once after deliberately opening the gate. The same patterns are also swept across every word address, so the address decode is covered in both states.

// File: rtl/lk_pkg.sv
package lk_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned KEY_W  = 16;

  typedef enum logic [1:0] {
    WK_NONE    = 2'd0,
    WK_ENGAGE  = 2'd1,
    WK_RELEASE = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/lk_rst_sync.sv
module lk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/lk_key_decode.sv
module lk_key_decode
  import lk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 2,
  parameter logic [KEY_W-1:0]  KEY       = 16'hD42F
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  output wr_kind_e          kind
);
  logic hit;
  assign hit = wr && (addr == LOCK_ADDR);

  always_comb begin
    kind = WK_NONE;
    if (hit) begin
      if (wdata[KEY_W-1:0] == KEY) kind = WK_ENGAGE;
      else if (wdata == '0)        kind = WK_RELEASE;
    end
  end
endmodule

// File: rtl/lk_state.sv
module lk_state
  import lk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wr_kind_e kind,
  output logic     open_q
);
  logic open_d;
  logic open_en;

  always_comb begin
    open_en = (kind != WK_NONE);
    open_d  = open_q;
    case (kind)
      WK_ENGAGE:  open_d = 1'b1;
      WK_RELEASE: open_d = 1'b0;
      default:    open_d = open_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_q <= 1'b0;
    else if (open_en) open_q <= open_d;
  end
endmodule

// File: rtl/lk_readback.sv
module lk_readback
  import lk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 2,
  parameter int unsigned STATUS_BIT = 31
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              open_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (addr == LOCK_ADDR) rdata[STATUS_BIT] = open_q;
  end
endmodule

// File: rtl/modelock_gate.sv
module modelock_gate
  import lk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 2,
  parameter int unsigned NUM_BANKS  = 3,
  parameter logic [KEY_W-1:0] KEY   = 16'hD42F,
  parameter int unsigned STATUS_BIT = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic                 reg_wr,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_BANKS-1:0] bank_mode_we
);
  logic     rst_core_n;
  wr_kind_e wr_kind;
  logic     gate_open;

  lk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  lk_key_decode #(.ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .KEY(KEY)) u_dec (
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .wr    (reg_wr),
    .kind  (wr_kind)
  );

  lk_state u_state (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .kind   (wr_kind),
    .open_q (gate_open)
  );

  lk_readback #(.ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .STATUS_BIT(STATUS_BIT)) u_rb (
    .addr   (reg_addr),
    .open_q (gate_open),
    .rdata  (reg_rdata)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_fan
    assign bank_mode_we[g] = gate_open;
  end
endmodule

// File: rtl/modelock_gate_chk.sv
module modelock_gate_chk
  import lk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 2,
  parameter int unsigned NUM_BANKS  = 3,
  parameter logic [KEY_W-1:0] KEY   = 16'hD42F,
  parameter int unsigned STATUS_BIT = 31
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [DATA_W-1:0]    reg_wdata,
  input logic                 reg_wr,
  input logic [DATA_W-1:0]    reg_rdata,
  input logic [NUM_BANKS-1:0] bank_mode_we
);
  logic lock_hit;
  assign lock_hit = reg_wr && (reg_addr == LOCK_ADDR);

  // R2
  engage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_hit && reg_wdata[KEY_W-1:0] == KEY) |=> bank_mode_we[0]);

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_hit && reg_wdata == '0) |=> !bank_mode_we[0]);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lock_hit && (reg_wdata[KEY_W-1:0] == KEY || reg_wdata == '0))) |=> $stable(bank_mode_we));

  // R6
  fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_mode_we == '0) || (&bank_mode_we));

  // R5
  status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == LOCK_ADDR) |-> (reg_rdata[STATUS_BIT] == bank_mode_we[0]
                                 && $countones(reg_rdata) <= 1));

  // R7
  other_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != LOCK_ADDR) |-> (reg_rdata == '0));

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_state_chk: assert (bank_mode_we == '0);
  end
endmodule

bind modelock_gate modelock_gate_chk #(
  .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .NUM_BANKS(NUM_BANKS),
  .KEY(KEY), .STATUS_BIT(STATUS_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_wr       (reg_wr),
  .reg_rdata    (reg_rdata),
  .bank_mode_we (bank_mode_we)
);

// File: tb/modelock_gate_test.sv
module modelock_gate_test;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] LOCK_ADDR = 4'd2;
  localparam int unsigned NB = 3;
  localparam logic [15:0] KEY = 16'hD42F;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata;
  logic              reg_wr;
  logic [31:0]       reg_rdata;
  logic [NB-1:0]     bank_mode_we;

  int  total;
  int  bad;
  bit  exp_open;
  bit  done;

  modelock_gate #(.ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .NUM_BANKS(NB), .KEY(KEY)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .bank_mode_we(bank_mode_we)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_state(input string req);
    logic [NB-1:0] exp_we;
    exp_we = exp_open ? {NB{1'b1}} : '0;
    total++;
    if (bank_mode_we !== exp_we) begin
      bad++;
      $display("FAIL %s: permit lines act=%b exp=%b", req, bank_mode_we, exp_we);
    end
    reg_addr = LOCK_ADDR;
    #1;
    total++;
    if (reg_rdata !== {exp_open, 31'b0}) begin
      bad++;
      $display("FAIL %s: lock word act=%h exp=%h", req, reg_rdata, {exp_open, 31'b0});
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == LOCK_ADDR) begin
      if (d[15:0] == KEY) exp_open = 1'b1;
      else if (d == 32'h0) exp_open = 1'b0;
    end
  endtask

  task automatic check_other_reads();
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      if (a[ADDR_W-1:0] != LOCK_ADDR) begin
        reg_addr = a[ADDR_W-1:0];
        #1;
        total++;
        if (reg_rdata !== 32'h0) begin
          bad++;
          $display("FAIL R7: read addr %0d act=%h exp=00000000", a, reg_rdata);
        end
      end
    end
  endtask

  initial begin
    total = 0; bad = 0; exp_open = 1'b0; done = 1'b0;
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1");

    // R2: plain key
    do_write(LOCK_ADDR, 32'h0000_D42F); check_state("R2");
    check_other_reads();
    // R3: release
    do_write(LOCK_ADDR, 32'h0); check_state("R3");
    // R8: upper bits ignored
    do_write(LOCK_ADDR, 32'hFFFF_D42F); check_state("R8");
    do_write(LOCK_ADDR, 32'h0); check_state("R3");
    do_write(LOCK_ADDR, 32'h8000_D42F); check_state("R8");

    // R4: single-bit key corruptions from open, then from closed
    for (int s = 0; s < 2; s++) begin
      for (int b = 0; b < 16; b++) begin
        do_write(LOCK_ADDR, {16'h0, KEY ^ (16'h1 << b)});
        check_state("R4");
      end
      do_write(LOCK_ADDR, 32'hD42F_0000); check_state("R4");
      do_write(LOCK_ADDR, 32'h8000_0000); check_state("R4");
      do_write(LOCK_ADDR, 32'h0000_0001); check_state("R4");
      do_write(LOCK_ADDR, 32'hFFFF_FFFF); check_state("R5");
      do_write(LOCK_ADDR, 32'h0); check_state("R3");
    end

    // R7: every other address, both gate states
    for (int s = 0; s < 2; s++) begin
      if (s == 1) begin
        do_write(LOCK_ADDR, 32'h0000_D42F);
        check_state("R2");
      end
      for (int a = 0; a < (1 << ADDR_W); a++) begin
        if (a[ADDR_W-1:0] != LOCK_ADDR) begin
          do_write(a[ADDR_W-1:0], 32'h0000_D42F); check_state("R7");
          do_write(a[ADDR_W-1:0], 32'h0);         check_state("R7");
        end
      end
      check_other_reads();
    end

    // R6: permit lines equal under toggling
    for (int i = 0; i < 8; i++) begin
      do_write(LOCK_ADDR, i[0] ? 32'h0 : 32'h1234_D42F);
      check_state("R6");
    end

    // R1: reset mid-operation while open
    do_write(LOCK_ADDR, 32'h0000_D42F);
    @(negedge clk); rst_n = 1'b0; exp_open = 1'b0;
    @(negedge clk);
    check_state("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule